// File: doc/BRIEF.md
# Receiver Inactivity Timeout Counter

This block is a 16-bit down-counter that sits beside a serial receiver. It measures how long the line has been quiet since the last character was handed to the receive holding register. Software turns the special timeout mode on or off with a 4-bit command code. While the mode is on, every character transfer strobe from the receiver stops the counter and reloads it from a preset held in two byte-wide registers, an upper and a lower one. The counter then restarts. If no further character arrives before the count runs out, a counter-ready flag is raised. When the interrupt mask bit is set, an interrupt request is also raised.

When timeout mode is off, the same counter responds to a plain start command, which loads the preset and counts, and to a plain stop command, which halts the counter and drops the flag. The counter advances only in cycles where the counter clock enable is high. The flag can also be cleared by a status-read strobe.

A character that arrives after expiry clears the flag and withdraws the interrupt. An interrupt that was seen a moment earlier can therefore find nothing pending when it is serviced.

Top module: `rx_idle_timer`

## Requirements
- R1: A command write with code 0xA turns timeout mode on, clears counter-ready in the next clock, and leaves the counter stopped: counter ticks cause no expiry until a character strobe arrives.
- R2: A command write with code 0xC turns timeout mode off. Afterwards character strobes neither clear counter-ready nor start the counter.
- R3: While timeout mode is on, the start code 0x8 and the stop code 0x9 have no effect on the counter or on counter-ready.
- R4: In timeout mode a character strobe stops the counter. The first counter tick after it loads the preset {upper byte, lower byte}, and each later tick decrements the count. A strobe that arrives mid-count restarts the full sequence.
- R5: With a preset N from 1 to 65535, counter-ready is set by the N-th tick after the reload tick and not before.
- R6: The interrupt output equals counter-ready AND the interrupt mask input. It is registered, so it follows a mask change one clock later.
- R7: A character strobe in timeout mode clears counter-ready and the interrupt in the next clock.
- R8: After expiry the counter stays stopped at zero. Further ticks raise no new expiry until a reload.
- R9: A preset of zero counts 65536 ticks after the reload tick.
- R10: With timeout mode off, code 0x8 runs the same reload-then-count sequence as R4, and code 0x9 stops the counter and clears counter-ready.
- R11: A status-read strobe clears counter-ready in the next clock, unless an expiry occurs in the same cycle, in which case the flag is set.
- R12: A synchronous active-high reset clears counter-ready and the interrupt, turns timeout mode off and stops the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_code | input | 4 | Command code field (0x8 start, 0x9 stop, 0xA timeout on, 0xC timeout off) |
| char_xfer | input | 1 | Character moved into the receive holding register |
| ct_tick | input | 1 | Counter clock enable |
| preset_hi | input | 8 | Upper preset byte |
| preset_lo | input | 8 | Lower preset byte |
| irq_mask | input | 1 | Interrupt mask bit for counter-ready |
| isr_read | input | 1 | Status-read strobe, clears counter-ready |
| ready | output | 1 | Counter-ready flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench counts ticks exactly around the reload tick. A design that decremented on the reload tick itself would expire one tick early, and a design that swapped the preset bytes would miss the 0x0102 expiry point. It restarts the counter mid-count and lets the line stay quiet after expiry, which catches a counter that wraps and fires again. It issues start and stop codes inside timeout mode and character strobes outside it, where a leaky decoder would start or stop the counter. It also checks the zero preset, where a plain 16-bit compare would expire at once or never.

// File: rtl/rxto_pkg.sv
`timescale 1ns/1ps
package rxto_pkg;
  typedef enum logic [3:0] {
    OP_START  = 4'h8,
    OP_STOP   = 4'h9,
    OP_TO_ON  = 4'hA,
    OP_TO_OFF = 4'hC
  } op_e;

  typedef enum logic [1:0] {
    CT_IDLE,
    CT_RELOAD,
    CT_RUN
  } ct_state_e;
endpackage

// File: rtl/rxto_cmd_dec.sv
`timescale 1ns/1ps
module rxto_cmd_dec
  import rxto_pkg::*;
#(
  parameter int CMD_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_we,
  input  logic [CMD_W-1:0] cmd_code,
  input  logic             char_xfer,
  output logic             to_mode,
  output logic             load_req,
  output logic             halt_req,
  output logic             ready_clr
);
  logic       mode_q, mode_d;
  logic [3:0] op;

  assign op      = cmd_code[CMD_W-1 -: 4];
  assign to_mode = mode_q;

  always_comb begin
    mode_d    = mode_q;
    load_req  = 1'b0;
    halt_req  = 1'b0;
    ready_clr = 1'b0;
    if (cmd_we) begin
      case (op)
        OP_TO_ON: begin
          mode_d    = 1'b1;
          halt_req  = 1'b1;
          ready_clr = 1'b1;
        end
        OP_TO_OFF: begin
          mode_d   = 1'b0;
          halt_req = 1'b1;
        end
        OP_START: begin
          if (!mode_q) load_req = 1'b1;
        end
        OP_STOP: begin
          if (!mode_q) begin
            halt_req  = 1'b1;
            ready_clr = 1'b1;
          end
        end
        default: ;
      endcase
    end else if (char_xfer && mode_q) begin
      load_req  = 1'b1;
      ready_clr = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= 1'b0;
    else     mode_q <= mode_d;
  end

  // R3: plain start/stop codes must not reach the counter in timeout mode
  a_r3_ignore_plain_cmds: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && mode_q && (op == OP_START || op == OP_STOP)) |-> (!load_req && !halt_req && !ready_clr));

  // R2: with timeout mode off a character strobe does nothing
  a_r2_char_ignored_off: assert property (@(posedge clk) disable iff (rst)
    (!cmd_we && !mode_q && char_xfer) |-> (!load_req && !ready_clr));

  // R1: enable command leaves mode on in the next clock
  a_r1_mode_on: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && op == OP_TO_ON) |=> mode_q);
endmodule

// File: rtl/rxto_downcnt.sv
`timescale 1ns/1ps
module rxto_downcnt
  import rxto_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load_req,
  input  logic             halt_req,
  input  logic [CNT_W-1:0] preset,
  output logic             expire
);
  localparam int CW = CNT_W + 1;

  ct_state_e       state_q;
  logic [CW-1:0]   count_q;
  logic [CW-1:0]   load_val;

  // zero preset stands for the full 2^CNT_W span
  assign load_val = (preset == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, preset};

  assign expire = (state_q == CT_RUN) && tick && (count_q == CW'(1)) &&
                  !load_req && !halt_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= CT_IDLE;
      count_q <= '0;
    end else if (halt_req) begin
      state_q <= CT_IDLE;
    end else if (load_req) begin
      state_q <= CT_RELOAD;
    end else if (tick) begin
      case (state_q)
        CT_RELOAD: begin
          count_q <= load_val;
          state_q <= CT_RUN;
        end
        CT_RUN: begin
          count_q <= count_q - CW'(1);
          if (count_q == CW'(1)) state_q <= CT_IDLE;
        end
        default: ;
      endcase
    end
  end

  // R4: the reload tick loads the preset and starts the run
  a_r4_reload_loads: assert property (@(posedge clk) disable iff (rst)
    (state_q == CT_RELOAD && tick && !load_req && !halt_req) |=>
      (state_q == CT_RUN && count_q == $past(load_val)));

  // R8: a stopped counter holds its value until reloaded
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (state_q == CT_IDLE && !load_req) |=> (state_q == CT_IDLE && $stable(count_q)));

  // R5: a running count never sits at zero
  a_r5_run_nonzero: assert property (@(posedge clk) disable iff (rst)
    (state_q == CT_RUN) |-> (count_q != '0));
endmodule

// File: rtl/rxto_flag.sv
`timescale 1ns/1ps
module rxto_flag (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic ready_clr,
  input  logic isr_read,
  input  logic irq_mask,
  output logic ready_o,
  output logic irq_o
);
  logic ready_q, irq_q, ready_nxt;

  always_comb begin
    if (expire)                    ready_nxt = 1'b1;
    else if (ready_clr || isr_read) ready_nxt = 1'b0;
    else                           ready_nxt = ready_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      ready_q <= ready_nxt;
      irq_q   <= ready_nxt & irq_mask;
    end
  end

  assign ready_o = ready_q;
  assign irq_o   = irq_q;

  // R5: expiry raises the flag
  a_r5_expire_sets: assert property (@(posedge clk) disable iff (rst)
    expire |=> ready_o);

  // R7 / R11: a clear without expiry drops the flag
  a_r7_clear_drops: assert property (@(posedge clk) disable iff (rst)
    ((ready_clr || isr_read) && !expire) |=> !ready_o);

  // R6: the interrupt is never raised without the flag
  a_r6_irq_needs_ready: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ready_o);

  // R12: reset clears both outputs
  a_r12_reset_clears: assert property (@(posedge clk)
    rst |=> (!ready_o && !irq_o));
endmodule

// File: rtl/rx_idle_timer.sv
`timescale 1ns/1ps
module rx_idle_timer #(
  parameter int CNT_W = 16,
  parameter int CMD_W = 4,
  localparam int HALF_W = CNT_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_we,
  input  logic [CMD_W-1:0]  cmd_code,
  input  logic              char_xfer,
  input  logic              ct_tick,
  input  logic [HALF_W-1:0] preset_hi,
  input  logic [HALF_W-1:0] preset_lo,
  input  logic              irq_mask,
  input  logic              isr_read,
  output logic              ready,
  output logic              irq
);
  logic to_mode, load_req, halt_req, ready_clr, expire;
  logic [CNT_W-1:0] preset;

  assign preset = {preset_hi, preset_lo};

  rxto_cmd_dec #(.CMD_W(CMD_W)) u_dec (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_code(cmd_code),
    .char_xfer(char_xfer), .to_mode(to_mode), .load_req(load_req),
    .halt_req(halt_req), .ready_clr(ready_clr)
  );

  rxto_downcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(ct_tick), .load_req(load_req),
    .halt_req(halt_req), .preset(preset), .expire(expire)
  );

  rxto_flag u_flag (
    .clk(clk), .rst(rst), .expire(expire), .ready_clr(ready_clr),
    .isr_read(isr_read), .irq_mask(irq_mask), .ready_o(ready), .irq_o(irq)
  );

  // R7: a character strobe in timeout mode withdraws the flag
  a_r7_char_withdraws: assert property (@(posedge clk) disable iff (rst)
    (to_mode && char_xfer && !cmd_we) |=> (!ready && !irq));
endmodule

// File: tb/test_rx_idle_timer.sv
`timescale 1ns/1ps
module test_rx_idle_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_we = 1'b0;
  logic [3:0] cmd_code = 4'h0;
  logic       char_xfer = 1'b0;
  logic       ct_tick = 1'b0;
  logic [7:0] preset_hi = 8'h00;
  logic [7:0] preset_lo = 8'h00;
  logic       irq_mask = 1'b0;
  logic       isr_read = 1'b0;
  logic       ready, irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  rx_idle_timer i_rx_idle_timer (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_code(cmd_code),
    .char_xfer(char_xfer), .ct_tick(ct_tick), .preset_hi(preset_hi),
    .preset_lo(preset_lo), .irq_mask(irq_mask), .isr_read(isr_read),
    .ready(ready), .irq(irq)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic write_cmd(input logic [3:0] c);
    cmd_we = 1'b1; cmd_code = c;
    @(negedge clk);
    cmd_we = 1'b0; cmd_code = 4'h0;
  endtask

  task automatic pulse_char();
    char_xfer = 1'b1;
    @(negedge clk);
    char_xfer = 1'b0;
  endtask

  task automatic pulse_read();
    isr_read = 1'b1;
    @(negedge clk);
    isr_read = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      ct_tick = 1'b1;
      @(negedge clk);
      ct_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic set_preset(input logic [15:0] v);
    preset_hi = v[15:8]; preset_lo = v[7:0];
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R12", "ready after reset", ready, 1'b0);
    chk("R12", "irq after reset", irq, 1'b0);
    set_preset(16'd2);
    pulse_char();
    ticks(6);
    chk("R12", "mode off after reset, char ignored", ready, 1'b0);
  endtask

  task automatic t_enable_stopped();
    irq_mask = 1'b1;
    set_preset(16'd3);
    write_cmd(4'hA);
    ticks(10);
    chk("R1", "stopped after enable", ready, 1'b0);
  endtask

  task automatic t_basic_expire();
    set_preset(16'd5);
    pulse_char();
    ticks(5);
    chk("R5", "ready before N-th tick", ready, 1'b0);
    chk("R6", "irq before expiry", irq, 1'b0);
    ticks(1);
    chk("R5", "ready on N-th tick", ready, 1'b1);
    chk("R6", "irq on expiry with mask", irq, 1'b1);
  endtask

  task automatic t_mask();
    irq_mask = 1'b0;
    @(negedge clk);
    chk("R6", "irq masked", irq, 1'b0);
    chk("R6", "ready kept while masked", ready, 1'b1);
    irq_mask = 1'b1;
    @(negedge clk);
    chk("R6", "irq unmasked", irq, 1'b1);
  endtask

  task automatic t_char_clears();
    pulse_char();
    chk("R7", "ready cleared by char", ready, 1'b0);
    chk("R7", "irq withdrawn by char", irq, 1'b0);
    ticks(6);
    chk("R5", "re-expiry after reload", ready, 1'b1);
  endtask

  task automatic t_stay_stopped();
    pulse_read();
    chk("R11", "read clears ready", ready, 1'b0);
    ticks(20);
    chk("R8", "no second expiry", ready, 1'b0);
  endtask

  task automatic t_restart_mid();
    set_preset(16'd6);
    pulse_char();
    ticks(5);
    pulse_char();
    ticks(6);
    chk("R4", "restart delays expiry", ready, 1'b0);
    ticks(1);
    chk("R4", "expiry after restart", ready, 1'b1);
  endtask

  task automatic t_ignore_plain();
    write_cmd(4'hA);
    chk("R1", "enable clears ready", ready, 1'b0);
    set_preset(16'd3);
    write_cmd(4'h8);
    ticks(10);
    chk("R3", "start ignored in timeout mode", ready, 1'b0);
    pulse_char();
    ticks(1);
    write_cmd(4'h9);
    ticks(3);
    chk("R3", "stop ignored in timeout mode", ready, 1'b1);
    write_cmd(4'h9);
    chk("R3", "stop does not clear in timeout mode", ready, 1'b1);
  endtask

  task automatic t_disable();
    pulse_read();
    write_cmd(4'hC);
    pulse_char();
    ticks(10);
    chk("R2", "char ignored after disable", ready, 1'b0);
    write_cmd(4'h8);
    ticks(3);
    chk("R10", "plain start not yet expired", ready, 1'b0);
    ticks(1);
    chk("R10", "plain start expires", ready, 1'b1);
    pulse_char();
    chk("R2", "char leaves ready set when off", ready, 1'b1);
    write_cmd(4'h8);
    ticks(1);
    write_cmd(4'h9);
    chk("R10", "plain stop clears ready", ready, 1'b0);
    ticks(10);
    chk("R10", "plain stop halts counter", ready, 1'b0);
  endtask

  task automatic t_hi_byte();
    set_preset(16'h0102);
    write_cmd(4'hA);
    pulse_char();
    ticks(258);
    chk("R4", "upper byte weight, before", ready, 1'b0);
    ticks(1);
    chk("R4", "upper byte weight, at 258", ready, 1'b1);
  endtask

  task automatic t_preset_zero();
    set_preset(16'h0000);
    pulse_char();
    chk("R9", "char clears before zero-preset run", ready, 1'b0);
    ct_tick = 1'b1;
    repeat (65536) @(negedge clk);
    chk("R9", "zero preset not expired at 65535", ready, 1'b0);
    @(negedge clk);
    ct_tick = 1'b0;
    chk("R9", "zero preset expires at 65536", ready, 1'b1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_enable_stopped();
    t_basic_expire();
    t_mask();
    t_char_clears();
    t_stay_stopped();
    t_restart_mid();
    t_ignore_plain();
    t_disable();
    t_hi_byte();
    t_preset_zero();
    finish_run();
  end

  initial begin
    #(20 * 190000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end
endmodule